// File: doc/BRIEF.md
# Two-Device Weight Programming Sequencer

This controller writes one signed target weight into a pair of resistive memory cells. The sign of the weight picks the pair. Both cells in that pair are first driven to their high-conductance state and then read back. The two readings are sorted, and the sorted values are compared with the target magnitude. The comparison leads to one of three outcomes. In the first, the weight is rejected because the pair cannot hold it. In the second, the weight is split across both cells, and only the weaker cell is trimmed. In the third, the weight is placed on the stronger cell alone, and the weaker cell is cleared.

Whenever the weight is accepted, a closed loop follows. The loop sends a trim pulse to the chosen cell and then reads it back. It stops when the reading lands within a tolerance of that cell's share of the target, or when a pulse budget runs out.

Every cell operation is a request on a command port that waits for an acknowledge. Read data comes back together with the acknowledge of a READ. The end of each job is reported by a one-cycle done pulse with a 2-bit status.

Top module: `wprog_ctrl`

## Requirements
- R1: The pair is chosen by the sign bit. Every command in a job carries cmd_dev[1] equal to the captured sign, and cmd_dev[0] selects the cell within the pair.
- R2: A job begins with SET to cell 0 and then SET to cell 1, followed by READ of cell 0 and then READ of cell 1. No other command comes first. Op codes: SET=0, RESET=1, PULSE=2, READ=3.
- R3: If the sum of the two readings is less than the target G, no further command is issued. Done follows with status 2 (rejected). The sum is formed one bit wider than a reading, so it cannot wrap.
- R4: If the larger reading is below G, no RESET is issued. The trim loop runs on the cell with the smaller reading, aiming at G minus the larger reading. A hit reports status 1.
- R5: If the larger reading is greater than or equal to G, the smaller-reading cell is RESET first. The trim loop then runs on the larger-reading cell, aiming at G. A hit reports status 0.
- R6: The trim loop alternates PULSE and READ on the chosen cell. It stops once the absolute difference between the read value and the aim is at most the tolerance.
- R7: After max_pulses pulses without a hit, the job ends with status 3 (timeout). At least one pulse is always sent, so a budget of 0 behaves as 1.
- R8: A command holds its op and device unchanged while cmd_valid is high and cmd_ack is low. The next command appears only after an acknowledge.
- R9: done is high for exactly one cycle per job, and status is valid with it. For a rejected job, done comes two cycles after the last READ acknowledge. Otherwise it comes one cycle after the final acknowledge.
- R10: start_ready is high only while idle. A start_valid seen while busy is ignored and leaves the running job unchanged.
- R11: While rst_n is low, cmd_valid and done are low and start_ready is high. Reset is asserted asynchronously and released on the clock.
- R12: When both readings are equal, cell 0 is treated as the larger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request to program a weight |
| start_ready | output | 1 | Controller idle, start accepted |
| tgt_sign | input | 1 | Weight sign, selects the cell pair |
| tgt_mag | input | GW | Target magnitude G |
| tol | input | GW | Allowed read error in the trim loop |
| max_pulses | input | PW | Trim pulse budget |
| cmd_valid | output | 1 | Command request |
| cmd_op | output | 2 | SET=0, RESET=1, PULSE=2, READ=3 |
| cmd_dev | output | 2 | {pair, cell} |
| cmd_ack | input | 1 | Command completed |
| rd_data | input | GW | Conductance, valid with the acknowledge of a READ |
| done | output | 1 | One-cycle job completion |
| status | output | 2 | 0 one cell, 1 two cells, 2 rejected, 3 timeout |

## Verification
The jobs cover both signs and every one of the four outcomes. Each decision boundary is hit exactly: a larger reading equal to G, which must take the one-cell path rather than the split path. A reading sum above the reading width, which would wrap if the adder were too narrow. Equal readings, which test the tie rule. A sum just below G, which must reject. Budgets of 0 and 4 separate the timeout count from the hit test. Acknowledge latencies from 0 to 3 cycles, a start request sent while busy, and a reset in the middle of a job check the handshake and idle behaviour.

// File: rtl/wprog_pkg.sv
package wprog_pkg;
  typedef enum logic [1:0] {
    OP_SET   = 2'd0,
    OP_RESET = 2'd1,
    OP_PULSE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_ONE     = 2'd0,
    ST_TWO     = 2'd1,
    ST_REJECT  = 2'd2,
    ST_TIMEOUT = 2'd3
  } stat_e;

  typedef enum logic [1:0] {
    PL_REJECT = 2'd0,
    PL_ONE    = 2'd1,
    PL_TWO    = 2'd2
  } plan_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SET0, S_SET1, S_RD0, S_RD1,
    S_DECIDE, S_CLEAR, S_PULSE, S_CHECK, S_DONE
  } fsm_e;
endpackage

// File: rtl/wprog_rst_sync.sv
module wprog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/wprog_sorter.sv
module wprog_sorter
  import wprog_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic [GW-1:0] ga,
  input  logic [GW-1:0] gb,
  input  logic [GW-1:0] tgt,
  output logic          max_is_b,
  output plan_e         plan,
  output logic [GW-1:0] share
);
  localparam int SW = GW + 1;

  logic [GW-1:0] gmax, gmin;
  logic [SW-1:0] sum;

  always_comb begin
    max_is_b = gb > ga;
    gmax     = max_is_b ? gb : ga;
    gmin     = max_is_b ? ga : gb;
    sum      = {1'b0, gmax} + {1'b0, gmin};
    if (sum < {1'b0, tgt})  plan = PL_REJECT;
    else if (gmax >= tgt)   plan = PL_ONE;
    else                    plan = PL_TWO;
    share = (plan == PL_TWO) ? (tgt - gmax) : tgt;
  end
endmodule

// File: rtl/wprog_verify.sv
module wprog_verify #(
  parameter int GW = 8
) (
  input  logic [GW-1:0] rd,
  input  logic [GW-1:0] goal,
  input  logic [GW-1:0] tol,
  output logic          hit
);
  logic [GW-1:0] diff;

  always_comb begin
    diff = (rd >= goal) ? (rd - goal) : (goal - rd);
    hit  = diff <= tol;
  end
endmodule

// File: rtl/wprog_ctrl.sv
module wprog_ctrl
  import wprog_pkg::*;
#(
  parameter int GW = 8,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic          tgt_sign,
  input  logic [GW-1:0] tgt_mag,
  input  logic [GW-1:0] tol,
  input  logic [PW-1:0] max_pulses,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [1:0]    cmd_dev,
  input  logic          cmd_ack,
  input  logic [GW-1:0] rd_data,
  output logic          done,
  output logic [1:0]    status
);
  logic rst_ni;

  wprog_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_ni)
  );

  fsm_e          state_q, state_d;
  logic          sign_q;
  logic [GW-1:0] tgt_q, tol_q, ga_q, gb_q, goal_q;
  logic [PW-1:0] maxp_q, cnt_q;
  logic          chosen_q, two_q;
  stat_e         stat_q, stat_d;

  logic          max_is_b, hit;
  plan_e         plan;
  logic [GW-1:0] share;
  op_e           op_c;
  logic          idx_c;

  wprog_sorter #(.GW(GW)) u_sort (
    .ga(ga_q), .gb(gb_q), .tgt(tgt_q),
    .max_is_b(max_is_b), .plan(plan), .share(share)
  );

  wprog_verify #(.GW(GW)) u_ver (
    .rd(rd_data), .goal(goal_q), .tol(tol_q), .hit(hit)
  );

  // enables
  logic cap_en, ga_en, gb_en, dec_en, cnt_clr, cnt_inc, stat_en;
  assign cap_en  = (state_q == S_IDLE) && start_valid;
  assign ga_en   = (state_q == S_RD0) && cmd_ack;
  assign gb_en   = (state_q == S_RD1) && cmd_ack;
  assign dec_en  = (state_q == S_DECIDE);
  assign cnt_clr = dec_en;
  assign cnt_inc = (state_q == S_PULSE) && cmd_ack;
  assign stat_en = (state_d == S_DONE) && (state_q != S_DONE);

  // next state and command decode
  always_comb begin
    state_d   = state_q;
    stat_d    = stat_q;
    cmd_valid = 1'b1;
    op_c      = OP_SET;
    idx_c     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        cmd_valid = 1'b0;
        if (start_valid) state_d = S_SET0;
      end
      S_SET0: begin
        if (cmd_ack) state_d = S_SET1;
      end
      S_SET1: begin
        idx_c = 1'b1;
        if (cmd_ack) state_d = S_RD0;
      end
      S_RD0: begin
        op_c = OP_READ;
        if (cmd_ack) state_d = S_RD1;
      end
      S_RD1: begin
        op_c  = OP_READ;
        idx_c = 1'b1;
        if (cmd_ack) state_d = S_DECIDE;
      end
      S_DECIDE: begin
        cmd_valid = 1'b0;
        case (plan)
          PL_REJECT: begin state_d = S_DONE; stat_d = ST_REJECT; end
          PL_ONE:    state_d = S_CLEAR;
          default:   state_d = S_PULSE;
        endcase
      end
      S_CLEAR: begin
        op_c  = OP_RESET;
        idx_c = ~chosen_q;
        if (cmd_ack) state_d = S_PULSE;
      end
      S_PULSE: begin
        op_c  = OP_PULSE;
        idx_c = chosen_q;
        if (cmd_ack) state_d = S_CHECK;
      end
      S_CHECK: begin
        op_c  = OP_READ;
        idx_c = chosen_q;
        if (cmd_ack) begin
          if (hit) begin
            state_d = S_DONE;
            stat_d  = two_q ? ST_TWO : ST_ONE;
          end else if (cnt_q >= maxp_q) begin
            state_d = S_DONE;
            stat_d  = ST_TIMEOUT;
          end else begin
            state_d = S_PULSE;
          end
        end
      end
      S_DONE: begin
        cmd_valid = 1'b0;
        state_d   = S_IDLE;
      end
      default: begin
        cmd_valid = 1'b0;
        state_d   = S_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      sign_q   <= 1'b0;
      tgt_q    <= '0;
      tol_q    <= '0;
      maxp_q   <= '0;
      ga_q     <= '0;
      gb_q     <= '0;
      goal_q   <= '0;
      chosen_q <= 1'b0;
      two_q    <= 1'b0;
      cnt_q    <= '0;
      stat_q   <= ST_ONE;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        sign_q <= tgt_sign;
        tgt_q  <= tgt_mag;
        tol_q  <= tol;
        maxp_q <= max_pulses;
      end
      if (ga_en) ga_q <= rd_data;
      if (gb_en) gb_q <= rd_data;
      if (dec_en) begin
        chosen_q <= (plan == PL_ONE) ? max_is_b : ~max_is_b;
        two_q    <= (plan == PL_TWO);
        goal_q   <= share;
      end
      if (cnt_clr)      cnt_q <= '0;
      else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign start_ready = (state_q == S_IDLE);
  assign cmd_op      = op_c;
  assign cmd_dev     = {sign_q, idx_c};
  assign done        = (state_q == S_DONE);
  assign status      = stat_q;

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_dev)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R3
  reject_path_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_DECIDE && plan == PL_REJECT) |=> (done && status == ST_REJECT));

  // R7
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_CHECK) |-> (cnt_q <= maxp_q || cnt_q == 1));

  // R10
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_ready && start_valid) |=> !start_ready);

  // R5
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid && cmd_op == OP_RESET) |-> (cnt_q == 0));
endmodule

// File: tb/wprog_ctrl_tb.sv
module wprog_ctrl_tb;
  localparam int GW = 8;
  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic          tgt_sign = 1'b0;
  logic [GW-1:0] tgt_mag = '0;
  logic [GW-1:0] tol = '0;
  logic [PW-1:0] max_pulses = '0;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [1:0]    cmd_dev;
  logic          cmd_ack = 1'b0;
  logic [GW-1:0] rd_data = '0;
  logic          done;
  logic [1:0]    status;

  always #4 clk = ~clk;

  wprog_ctrl #(.GW(GW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .tgt_sign(tgt_sign), .tgt_mag(tgt_mag), .tol(tol), .max_pulses(max_pulses),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_ack(cmd_ack),
    .rd_data(rd_data), .done(done), .status(status)
  );

  int    nvec = 0, nbad = 0, cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  int    exp_st = 0, last_delay = 1, due = 0;
  int    setv[4];
  int    gdev[4];
  int    step = 1, lat = 0, w = 0, held = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural expectation of the whole command stream
  task automatic plan_job(input bit sg, input int g, input int tl, input int mp,
                          input int s0, input int s1);
    int mx, mi, mxi, mii, ch, aim, cur, n, d, lim;
    string rq;
    exp_q.delete(); tag_q.delete();
    exp_q.push_back(0*4 + sg*2 + 0); tag_q.push_back("R2/R1 set0");
    exp_q.push_back(0*4 + sg*2 + 1); tag_q.push_back("R2/R1 set1");
    exp_q.push_back(3*4 + sg*2 + 0); tag_q.push_back("R2 read0");
    exp_q.push_back(3*4 + sg*2 + 1); tag_q.push_back("R2 read1");
    if (s1 > s0) begin mx = s1; mi = s0; mxi = 1; end
    else begin mx = s0; mi = s1; mxi = 0; end   // R12 tie rule
    mii = 1 - mxi;
    if (mx + mi < g) begin
      exp_st = 2; last_delay = 2;
      return;
    end
    last_delay = 1;
    if (mx >= g) begin
      exp_q.push_back(1*4 + sg*2 + mii); tag_q.push_back("R5 reset min");
      ch = mxi; aim = g; cur = mx; rq = "R5";
    end else begin
      ch = mii; aim = g - mx; cur = mi; rq = "R4";
    end
    lim = (mp < 1) ? 1 : mp;
    for (n = 1; n <= 64; n++) begin
      cur = (cur > step) ? cur - step : 0;
      exp_q.push_back(2*4 + sg*2 + ch); tag_q.push_back({rq, "/R6 pulse"});
      exp_q.push_back(3*4 + sg*2 + ch); tag_q.push_back({rq, "/R6 verify"});
      d = cur - aim; if (d < 0) d = -d;
      if (d <= tl) begin exp_st = (rq == "R5") ? 0 : 1; break; end
      if (n >= lim) begin exp_st = 3; break; end
    end
  endtask

  // device model, checker and watchdog on every falling edge
  always @(negedge clk) begin
    int e, c, dv;
    string t;
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
    if (!rst_n) begin
      cmd_ack = 1'b0; w = 0;
    end else begin
      if (due > 0) begin
        due--;
        if (due == 0) check(done && status == exp_st, "R9 done/status", {done, status}, 4 + exp_st);
        else if (done) check(1'b0, "R9 early done", 1, 0);
      end else if (done) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end
      if (cmd_ack) begin
        cmd_ack = 1'b0; w = 0;
      end else if (cmd_valid) begin
        c = cmd_op * 4 + cmd_dev;
        if (w == 0) held = c;
        else if (c != held) check(1'b0, "R8 cmd changed while waiting", c, held);
        if (w >= lat) begin
          if (exp_q.size() == 0) check(1'b0, "R3/R10 extra command", c, -1);
          else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(c == e, t, c, e);
            if (exp_q.size() == 0) due = last_delay;
          end
          dv = cmd_dev;
          case (cmd_op)
            2'd0: gdev[dv] = setv[dv];
            2'd1: gdev[dv] = 0;
            2'd2: gdev[dv] = (gdev[dv] > step) ? gdev[dv] - step : 0;
            default: ;
          endcase
          rd_data = gdev[dv][GW-1:0];
          cmd_ack = 1'b1;
        end else w++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    check(!cmd_valid && !done && start_ready, "R11 reset outputs",
          {cmd_valid, done, start_ready}, 1);
    exp_q.delete(); tag_q.delete(); due = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input bit sg, input int g, input int tl, input int mp,
                     input int s0, input int s1, input int st, input int lt,
                     input bit poke, input bit abort);
    int k;
    step = st; lat = lt;
    setv[sg*2] = s0; setv[sg*2+1] = s1;
    setv[(1-sg)*2] = 7; setv[(1-sg)*2+1] = 9;
    plan_job(sg, g, tl, mp, s0, s1);
    @(negedge clk);
    check(start_ready, "R10 ready when idle", start_ready, 1);
    start_valid = 1'b1; tgt_sign = sg; tgt_mag = g[GW-1:0];
    tol = tl[GW-1:0]; max_pulses = mp[PW-1:0];
    @(negedge clk);
    start_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      check(!start_ready, "R10 busy", start_ready, 0);
      start_valid = 1'b1; tgt_sign = ~sg; tgt_mag = 8'd3; tol = 8'd0;
      repeat (3) @(negedge clk);
      start_valid = 1'b0;
    end
    if (abort) begin
      repeat (5) @(negedge clk);
      do_reset();
      return;
    end
    k = 0;
    while ((exp_q.size() > 0 || due > 0) && k < 5000) begin
      @(negedge clk); k++;
    end
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 stream completed", exp_q.size(), 0);
    check(start_ready, "R10 idle after done", start_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    // R5 one-cell, positive pair, exact landing
    run(1'b0, 150, 3, 20, 200, 120, 10, 0, 1'b0, 1'b0);
    // R4 split, negative pair, slow ack
    run(1'b1, 130, 2, 20, 60, 90, 7, 2, 1'b0, 1'b0);
    // R3 reject, sum just below target
    run(1'b0, 100, 1, 10, 50, 49, 3, 1, 1'b0, 1'b0);
    // R3 sum beyond reading width, R12 tie, split
    run(1'b1, 255, 5, 10, 200, 200, 50, 0, 1'b0, 1'b0);
    // R5 larger reading equal to target
    run(1'b0, 130, 4, 10, 100, 130, 4, 3, 1'b0, 1'b0);
    // R7 timeout after four pulses
    run(1'b1, 100, 1, 4, 250, 10, 5, 1, 1'b0, 1'b0);
    // R7 zero budget behaves as one
    run(1'b0, 100, 1, 0, 10, 250, 5, 0, 1'b0, 1'b0);
    // R12 equal readings, one-cell path
    run(1'b0, 100, 2, 30, 180, 180, 20, 1, 1'b0, 1'b0);
    // R10 start while busy is ignored
    run(1'b1, 150, 3, 20, 120, 200, 10, 2, 1'b1, 1'b0);
    // R11 reset in the middle of a job, then a clean job
    run(1'b0, 150, 3, 20, 200, 120, 10, 1, 1'b0, 1'b1);
    run(1'b0, 150, 3, 20, 200, 120, 10, 1, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule